// File: doc/BRIEF.md
# Adapter-Good Rising Deglitch Controller

This block decides when a freshly connected power adapter is trusted. It watches two digitised comparator levels on the adapter detect node, a high detect level and a much lower reset level. It raises `acok` only once the high detect level has stayed continuously present for a deglitch time, counted in millisecond ticks. The output drops on the clock edge that follows any loss of the detect level. Any glitch during the wait starts the count again from zero.

Two deglitch lengths are available: a short one, which is the default, and a long one, chosen by an option input. The long length is not applied as soon as the option is set. It becomes eligible only after two things have happened: the detect level has fallen from high, and after that fall the switch-drive input has been seen off at least once. From then on it applies to each later rise.

The first assertion after reset always uses the short length. A drop below the reset level clears the eligibility, so the next rise is short again. The length for a window is fixed at the rise that opens it.

Top module: `acok_deglitch`

## Requirements
- R1: While reset is asserted and right after its release, `acok` is 0.
- R2: When the effective detect level (`det_hi` and `det_lo` both 1) is continuously 1 and the short length is selected, `acok` becomes 1 on the clock edge that samples the SHORT_MS-th `tick_ms` pulse counted since the rise, and not earlier.
- R3: The first rise after reset uses the short length, even when `long_sel` is 1.
- R4: A rise uses the long length (LONG_MS ticks) when three conditions hold: `long_sel` is 1 on the rise cycle; an earlier high-to-low fall of the effective level has occurred since the last reset or deep drop; and `acfet_on` was sampled 0 on or after that fall. Once armed, the long length stays armed for later rises until a deep drop.
- R5: If `acfet_on` stays 1 through and after every fall, later rises keep the short length.
- R6: A rise with `long_sel` at 0 uses the short length, even when the long length is armed.
- R7: `acok` returns to 0 on the first clock edge that samples the effective level at 0, with no deglitch.
- R8: A drop of the effective level during the deglitch wait restarts the count from zero, so the next rise needs a full length of ticks.
- R9: `det_lo` at 0 forces `acok` to 0 and clears the long-length arming, so the next rise is short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| det_hi | input | 1 | Adapter detect above the high threshold |
| det_lo | input | 1 | Adapter detect above the reset threshold |
| acfet_on | input | 1 | Adapter switch drive currently on |
| long_sel | input | 1 | Option: request the long deglitch |
| acok | output | 1 | Adapter good |

## Verification
The bench builds the block with SHORT_MS=4 and LONG_MS=9, so both deglitch lengths complete within a few dozen cycles. The two lengths can therefore be told apart by counting ticks. A single run can then step through the full arming life cycle: the first rise, a fall with the drive held on, a fall with the drive released, the option turned off, a deep drop, and a mid-window glitch.

// File: rtl/acok_dg_pkg.sv
package acok_dg_pkg;
  typedef enum logic {
    DLY_SHORT = 1'b0,
    DLY_LONG  = 1'b1
  } dly_sel_e;
endpackage

// File: rtl/acok_arm_track.sv
module acok_arm_track
  import acok_dg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl,
  input  logic     det_lo,
  input  logic     acfet_on,
  input  logic     long_sel,
  output dly_sel_e dly_sel
);
  logic prev_q, fall_q, off_q;
  dly_sel_e long_q;
  logic prev_n, fall_n, off_n;
  dly_sel_e long_n;
  logic rise, drop, arm_ok;

  always_comb begin
    drop   = prev_q & ~lvl;
    rise   = lvl & ~prev_q;
    arm_ok = long_sel & fall_q & off_q;
    prev_n = lvl;
    fall_n = fall_q | drop;
    off_n  = off_q | (fall_n & ~acfet_on);
    long_n = long_q;
    if (rise) long_n = arm_ok ? DLY_LONG : DLY_SHORT;
    if (!det_lo) begin
      prev_n = 1'b0;
      fall_n = 1'b0;
      off_n  = 1'b0;
      long_n = DLY_SHORT;
    end
    dly_sel = rise ? (arm_ok ? DLY_LONG : DLY_SHORT) : long_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      fall_q <= 1'b0;
      off_q  <= 1'b0;
      long_q <= DLY_SHORT;
    end else begin
      prev_q <= prev_n;
      fall_q <= fall_n;
      off_q  <= off_n;
      long_q <= long_n;
    end
  end

  AST_DEEP_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    !det_lo |=> (long_q == DLY_SHORT && !fall_q && !off_q)); // R9
  AST_FIRST_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_q |-> (dly_sel == DLY_SHORT)); // R3
endmodule

// File: rtl/acok_dg_timer.sv
module acok_dg_timer
  import acok_dg_pkg::*;
#(
  parameter int SHORT_MS = 150,
  parameter int LONG_MS  = 1300
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     lvl,
  input  dly_sel_e dly_sel,
  output logic     ok
);
  localparam int CW = $clog2(LONG_MS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LONG_MS);

  logic [CW-1:0] cnt_q, cnt_n, inc, lim;
  logic ok_q, ok_n;

  always_comb begin
    lim   = (dly_sel == DLY_LONG) ? CW'(LONG_MS) : CW'(SHORT_MS);
    inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    cnt_n = cnt_q;
    ok_n  = ok_q;
    if (!lvl) begin
      cnt_n = '0;
      ok_n  = 1'b0;
    end else if (!ok_q && tick) begin
      cnt_n = inc;
      if (inc >= lim) ok_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ok_q  <= ok_n;
    end
  end

  assign ok = ok_q;

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |=> !ok_q); // R7
  AST_RISE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(lvl)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q >= $past(cnt_q))); // R8
endmodule

// File: rtl/acok_deglitch.sv
module acok_deglitch
  import acok_dg_pkg::*;
#(
  parameter int SHORT_MS = 150,
  parameter int LONG_MS  = 1300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic det_hi,
  input  logic det_lo,
  input  logic acfet_on,
  input  logic long_sel,
  output logic acok
);
  logic     lvl;
  dly_sel_e dly_sel;

  assign lvl = det_hi & det_lo;

  acok_arm_track u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .det_lo   (det_lo),
    .acfet_on (acfet_on),
    .long_sel (long_sel),
    .dly_sel  (dly_sel)
  );

  acok_dg_timer #(
    .SHORT_MS (SHORT_MS),
    .LONG_MS  (LONG_MS)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_ms),
    .lvl     (lvl),
    .dly_sel (dly_sel),
    .ok      (acok)
  );

  AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acok) |-> $past(det_lo)); // R9
endmodule

// File: tb/acok_deglitch_tb_top.sv
module acok_deglitch_tb_top;
  localparam int SH = 4;
  localparam int LG = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, det_hi = 1'b0, det_lo = 1'b0;
  logic acfet_on = 1'b0, long_sel = 1'b0;
  logic acok;

  int total = 0, bad = 0, phase = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  acok_deglitch #(.SHORT_MS(SH), .LONG_MS(LG)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .det_hi(det_hi),
    .det_lo(det_lo), .acfet_on(acfet_on), .long_sel(long_sel), .acok(acok));

  // behavioural reference model
  int  m_cnt;
  bit  m_ok, m_prev, m_fall, m_off, m_long;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ok = 0; m_prev = 0; m_fall = 0; m_off = 0; m_long = 0;
    end else if (!det_lo) begin
      m_cnt = 0; m_ok = 0; m_prev = 0; m_fall = 0; m_off = 0; m_long = 0;
    end else begin
      bit lv;
      int need;
      lv = det_hi;
      if (lv && !m_prev) m_long = long_sel && m_fall && m_off;
      if (m_prev && !lv) m_fall = 1;
      if (m_fall && !acfet_on) m_off = 1;
      need = m_long ? LG : SH;
      if (!lv) begin
        m_cnt = 0; m_ok = 0;
      end else if (!m_ok && tick_ms) begin
        if (m_cnt < LG) m_cnt = m_cnt + 1;
        if (m_cnt >= need) m_ok = 1;
      end
      m_prev = lv;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(cur_req, acok, m_ok);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic adv();
    @(negedge clk);
    tick_ms = (phase == 2);
    phase = (phase + 1) % 3;
  endtask

  task automatic rise_wait(string req, int exp);
    int n = 0;
    cur_req = req;
    tick_ms = 0;
    det_hi = 1;
    for (int i = 0; i < 200; i++) begin
      adv();
      if (acok) break;
      if (tick_ms) n++;
    end
    check(req, n, exp);
  endtask

  task automatic drop(string req);
    cur_req = req;
    det_hi = 0;
    adv();
    adv();
    check(req, acok, 0);
  endtask

  initial begin
    det_lo = 1;
    repeat (3) @(negedge clk);
    check("R1", acok, 0);
    rst_n = 1;
    adv();
    check("R1", acok, 0);

    long_sel = 1; acfet_on = 0;
    rise_wait("R3", SH);
    acfet_on = 1;
    drop("R7");
    repeat (4) adv();
    rise_wait("R5", SH);

    drop("R7");
    acfet_on = 0; adv(); acfet_on = 1; adv();
    rise_wait("R4", LG);

    drop("R4");
    long_sel = 0;
    rise_wait("R6", SH);

    long_sel = 1;
    drop("R4");
    rise_wait("R4", LG);

    cur_req = "R9";
    det_lo = 0; det_hi = 0;
    repeat (3) adv();
    check("R9", acok, 0);
    det_lo = 1;
    adv();
    rise_wait("R9", SH);

    drop("R8");
    cur_req = "R8";
    det_hi = 1;
    repeat (7) adv();
    check("R8", acok, 0);
    det_hi = 0; adv();
    rise_wait("R8", SH);

    repeat (3) adv();
    check("R2", acok, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule